// File: doc/BRIEF.md
# Split Word Read Bridge

This block connects a byte-addressed requester to a storage array whose rows are 16 bits wide. It answers three kinds of read: single bytes, words that start on an even address, and words that start on an odd address. An odd-start word covers two rows. The bridge reads both rows one after the other and joins the two bytes, with the byte at the requested address as the most significant byte.

Writes are allowed only as single bytes or as even-aligned words. A byte write uses per-lane byte enables, so the other half of the row keeps its value. An odd-start word write is rejected. It makes no array access and returns an error flag.

The array is a synchronous RAM: the row selected in one cycle shows on the read data bus in the next cycle. A request is taken in any cycle where `reqValid` is high and `busy` is low. The requester holds the request until it is taken.

Top module: `split_word_bridge`

## Requirements
- R1: A byte read at an even address returns the upper lane (bits 15:8) of its row on `rspRdata[7:0]`, with bits 15:8 zero. `rspReady` is high for one cycle, in the cycle after the request is taken.
- R2: A byte read at an odd address returns the lower lane (bits 7:0) of its row in the same form and with the same timing as R1.
- R3: A word read at an even address n returns byte n in bits 15:8 and byte n+1 in bits 7:0, in the cycle after the request is taken. Such reads may follow one another in consecutive cycles.
- R4: A word read at an odd address n reads row n/2 and then the next row. It returns byte n in bits 15:8 and byte n+1 in bits 7:0. `rspReady` rises two cycles after the request is taken and stays low in the cycle between.
- R5: An odd-address word read at the highest byte address takes its low byte from the upper lane of row 0.
- R6: `busy` is high for exactly the one cycle after an odd-address word read is taken. A request presented during that cycle is not taken and has no effect on the array.
- R7: A byte write at an even address changes only the upper lane of its row (`memBe` = 2'b10). At an odd address it changes only the lower lane (`memBe` = 2'b01). The data comes from `reqWdata[7:0]`, and `rspReady` follows one cycle later without `rspError`.
- R8: A word write at an even address n stores `reqWdata[15:8]` as byte n and `reqWdata[7:0]` as byte n+1, with `memBe` = 2'b11.
- R9: A word write at an odd address drives no array access. It raises `rspError` and `rspReady` together for one cycle, in the cycle after it is taken, and the array contents do not change.
- R10: During and right after reset, `rspReady`, `rspError`, `busy` and `memEn` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWord | input | 1 | 1 = 16-bit access, 0 = byte access |
| reqAddr | input | ADDR_W | Byte address |
| reqWdata | input | 16 | Write data (byte writes use bits 7:0) |
| busy | output | 1 | Second row of a split read in progress; requests not taken |
| rspReady | output | 1 | Response valid for one cycle |
| rspError | output | 1 | Rejected misaligned write |
| rspRdata | output | 16 | Read data |
| memEn | output | 1 | Array access enable |
| memWe | output | 1 | Array write enable |
| memBe | output | 2 | Lane enables: bit 1 = bits 15:8, bit 0 = bits 7:0 |
| memRow | output | ADDR_W-1 | Row index |
| memWdata | output | 16 | Array write data |
| memRdata | input | 16 | Array read data, valid the cycle after access |

## Verification
Two events can fall in the same cycle. The first case is the second row access of a split read while a new request arrives. The bench presents a byte write during the `busy` cycle and withdraws it afterwards. It then checks that the split result is correct and, by reading that location back, that the write never reached the array. The second case is a response leaving the bridge in the same cycle a new request is taken. The bench issues aligned reads back to back and checks each result in its own cycle.

// File: rtl/split_word_pkg.sv
`timescale 1ns/1ps
package split_word_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [2:0] {
    RSP_NONE,
    RSP_BYTE_HI,
    RSP_BYTE_LO,
    RSP_WORD,
    RSP_SPLIT,
    RSP_WRITE,
    RSP_ERR
  } rspKind_t;

  typedef struct packed {
    logic     accept;
    logic     memEn;
    logic     memWe;
    logic     secondRow;
    logic     holdByte;
    rspKind_t rsp;
  } ctlStrobe_t;
endpackage

// File: rtl/split_word_ctrl.sv
`timescale 1ns/1ps
module split_word_ctrl
  import split_word_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       reqWord,
  input  logic       reqOdd,
  output logic       busy,
  output ctlStrobe_t strobe
);
  typedef enum logic {ST_IDLE, ST_SECOND} state_t;

  state_t   state, stateNext;
  rspKind_t rspQ, rspNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    rspNext   = RSP_NONE;
    if (state == ST_SECOND) begin
      strobe.memEn     = 1'b1;
      strobe.secondRow = 1'b1;
      strobe.holdByte  = 1'b1;
      rspNext          = RSP_SPLIT;
      stateNext        = ST_IDLE;
    end else if (reqValid) begin
      strobe.accept = 1'b1;
      if (reqWrite) begin
        if (reqWord && reqOdd) begin
          rspNext = RSP_ERR;
        end else begin
          strobe.memEn = 1'b1;
          strobe.memWe = 1'b1;
          rspNext      = RSP_WRITE;
        end
      end else begin
        strobe.memEn = 1'b1;
        if (reqWord && reqOdd) stateNext = ST_SECOND;
        else if (reqWord)      rspNext   = RSP_WORD;
        else if (reqOdd)       rspNext   = RSP_BYTE_LO;
        else                   rspNext   = RSP_BYTE_HI;
      end
    end
    strobe.rsp = rspQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      rspQ  <= RSP_NONE;
    end else begin
      state <= stateNext;
      rspQ  <= rspNext;
    end
  end

  assign busy = (state == ST_SECOND);

  assert_busy_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);
  assert_busy_reads_only_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (strobe.memEn && !strobe.memWe && !strobe.accept));
  assert_split_ready_after_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (strobe.rsp == RSP_SPLIT));
endmodule

// File: rtl/split_word_dpath.sv
`timescale 1ns/1ps
module split_word_dpath
  import split_word_pkg::*;
#(
  parameter int ADDR_W = 10,
  localparam int ROW_W = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWord,
  input  logic [WORD_W-1:0] reqWdata,
  input  logic [WORD_W-1:0] memRdata,
  output logic              memEn,
  output logic              memWe,
  output logic [1:0]        memBe,
  output logic [ROW_W-1:0]  memRow,
  output logic [WORD_W-1:0] memWdata,
  output logic              rspReady,
  output logic              rspError,
  output logic [WORD_W-1:0] rspRdata
);
  localparam logic [ROW_W-1:0] ROW_ONE = {{(ROW_W-1){1'b0}}, 1'b1};

  logic [ROW_W-1:0]  rowQ;
  logic [BYTE_W-1:0] savedQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowQ   <= '0;
      savedQ <= '0;
    end else begin
      if (strobe.accept)   rowQ   <= reqAddr[ADDR_W-1:1];
      if (strobe.holdByte) savedQ <= memRdata[BYTE_W-1:0];
    end
  end

  assign memEn  = strobe.memEn;
  assign memWe  = strobe.memWe;
  assign memRow = strobe.secondRow ? (rowQ + ROW_ONE) : reqAddr[ADDR_W-1:1];

  always_comb begin
    if (strobe.secondRow || reqWord) memBe = 2'b11;
    else if (reqAddr[0])             memBe = 2'b01;
    else                             memBe = 2'b10;
  end

  assign memWdata = reqWord ? reqWdata : {2{reqWdata[BYTE_W-1:0]}};

  always_comb begin
    rspReady = (strobe.rsp != RSP_NONE);
    rspError = (strobe.rsp == RSP_ERR);
    case (strobe.rsp)
      RSP_BYTE_HI: rspRdata = {{BYTE_W{1'b0}}, memRdata[WORD_W-1:BYTE_W]};
      RSP_BYTE_LO: rspRdata = {{BYTE_W{1'b0}}, memRdata[BYTE_W-1:0]};
      RSP_WORD:    rspRdata = memRdata;
      RSP_SPLIT:   rspRdata = {savedQ, memRdata[WORD_W-1:BYTE_W]};
      default:     rspRdata = '0;
    endcase
  end

  assert_second_row_follows_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.secondRow |-> (memRow == ($past(memRow) + ROW_ONE)));
  assert_byte_write_one_lane_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memWe && !reqWord) |-> ($countones(memBe) == 1));
endmodule

// File: rtl/split_word_bridge.sv
`timescale 1ns/1ps
module split_word_bridge
  import split_word_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqWord,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [15:0]       reqWdata,
  output logic              busy,
  output logic              rspReady,
  output logic              rspError,
  output logic [15:0]       rspRdata,
  output logic              memEn,
  output logic              memWe,
  output logic [1:0]        memBe,
  output logic [ADDR_W-2:0] memRow,
  output logic [15:0]       memWdata,
  input  logic [15:0]       memRdata
);
  ctlStrobe_t strobe;

  split_word_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqWord  (reqWord),
    .reqOdd   (reqAddr[0]),
    .busy     (busy),
    .strobe   (strobe)
  );

  split_word_dpath #(.ADDR_W(ADDR_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqWord  (reqWord),
    .reqWdata (reqWdata),
    .memRdata (memRdata),
    .memEn    (memEn),
    .memWe    (memWe),
    .memBe    (memBe),
    .memRow   (memRow),
    .memWdata (memWdata),
    .rspReady (rspReady),
    .rspError (rspError),
    .rspRdata (rspRdata)
  );

  assert_bad_write_no_access_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && reqWrite && reqWord && reqAddr[0]) |-> !memEn);
  assert_bad_write_flags_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && reqWrite && reqWord && reqAddr[0]) |=> (rspError && rspReady));
  assert_error_with_ready_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspError |-> rspReady);
endmodule

// File: tb/split_word_bridge_tb.sv
`timescale 1ns/1ps
module split_word_bridge_tb;
  localparam int ADDR_W = 10;
  localparam int BYTES  = 1 << ADDR_W;
  localparam int ROWS   = BYTES / 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqWord = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic busy, rspReady, rspError, memEn, memWe;
  logic [15:0] rspRdata, memWdata, memRdata;
  logic [1:0] memBe;
  logic [ADDR_W-2:0] memRow;

  logic [15:0] ram [ROWS];
  logic [7:0]  refB [BYTES];
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  split_word_bridge #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqWord(reqWord), .reqAddr(reqAddr), .reqWdata(reqWdata), .busy(busy),
    .rspReady(rspReady), .rspError(rspError), .rspRdata(rspRdata),
    .memEn(memEn), .memWe(memWe), .memBe(memBe), .memRow(memRow),
    .memWdata(memWdata), .memRdata(memRdata)
  );

  always @(posedge clk) begin
    if (memEn) begin
      if (memWe && memBe[1]) ram[memRow][15:8] <= memWdata[15:8];
      if (memWe && memBe[0]) ram[memRow][7:0]  <= memWdata[7:0];
      memRdata <= ram[memRow];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expWord(input int a);
    return {refB[a], refB[(a + 1) % BYTES]};
  endfunction

  task automatic drive(input bit wr, input bit wd, input int a, input logic [15:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqWord = wd;
    reqAddr = ADDR_W'(a); reqWdata = d;
  endtask

  task automatic release_req();
    reqValid = 1'b0; reqWrite = 1'b0; reqWord = 1'b0;
  endtask

  task automatic doRead(input bit wd, input int a, input string req);
    logic [15:0] exp;
    exp = wd ? expWord(a) : {8'h00, refB[a]};
    drive(1'b0, wd, a, 16'h0);
    @(negedge clk);
    release_req();
    if (wd && a[0]) begin
      chk(busy && !rspReady, req, {busy, rspReady}, 2'b10);
      @(negedge clk);
    end
    chk(rspReady && !rspError && rspRdata == exp, req, {rspReady, rspRdata}, {1'b1, exp});
  endtask

  task automatic doWrite(input bit wd, input int a, input logic [15:0] d, input string req);
    drive(1'b1, wd, a, d);
    @(negedge clk);
    release_req();
    chk(rspReady && !rspError, req, {rspReady, rspError}, 2'b10);
    if (wd) begin
      refB[a] = d[15:8]; refB[a + 1] = d[7:0];
    end else begin
      refB[a] = d[7:0];
    end
  endtask

  task automatic tReset();
    @(negedge clk);
    chk(!rspReady && !rspError && !busy && !memEn, "R10", {rspReady, rspError, busy, memEn}, 4'b0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!rspReady && !rspError && !busy && !memEn, "R10", {rspReady, rspError, busy, memEn}, 4'b0);
  endtask

  task automatic tByteReads();
    doRead(1'b0, 12, "R1");
    doRead(1'b0, 512, "R1");
    doRead(1'b0, 13, "R2");
    doRead(1'b0, BYTES - 1, "R2");
  endtask

  task automatic tWordReads();
    doRead(1'b1, 40, "R3");
    doRead(1'b1, 0, "R3");
  endtask

  task automatic tBackToBack();
    drive(1'b0, 1'b1, 100, 16'h0);
    drive(1'b0, 1'b0, 101, 16'h0);
    chk(rspReady && rspRdata == expWord(100), "R3", rspRdata, expWord(100));
    @(negedge clk);
    release_req();
    chk(rspReady && rspRdata == {8'h00, refB[101]}, "R3", rspRdata, {8'h00, refB[101]});
  endtask

  task automatic tSplitReads();
    doRead(1'b1, 41, "R4");
    doRead(1'b1, 301, "R4");
  endtask

  task automatic tWrap();
    doRead(1'b1, BYTES - 1, "R5");
  endtask

  task automatic tHeldOff();
    logic [15:0] exp;
    exp = expWord(77);
    drive(1'b0, 1'b1, 77, 16'h0);
    @(negedge clk);
    chk(busy, "R6", busy, 1'b1);
    reqWrite = 1'b1; reqWord = 1'b0; reqAddr = ADDR_W'(200); reqWdata = 16'h005A;
    @(negedge clk);
    release_req();
    chk(!busy && rspReady && rspRdata == exp, "R6", rspRdata, exp);
    doRead(1'b0, 200, "R6");
  endtask

  task automatic tByteWrites();
    drive(1'b1, 1'b0, 60, 16'h00C3);
    #1 chk(memEn && memWe && memBe == 2'b10, "R7", memBe, 2'b10);
    @(negedge clk);
    release_req();
    chk(rspReady && !rspError, "R7", {rspReady, rspError}, 2'b10);
    refB[60] = 8'hC3;
    doRead(1'b1, 60, "R7");
    doWrite(1'b0, 63, 16'hFF3C, "R7");
    doRead(1'b1, 62, "R7");
  endtask

  task automatic tWordWrites();
    drive(1'b1, 1'b1, 90, 16'hBEEF);
    #1 chk(memEn && memWe && memBe == 2'b11, "R8", memBe, 2'b11);
    @(negedge clk);
    release_req();
    refB[90] = 8'hBE; refB[91] = 8'hEF;
    doRead(1'b1, 90, "R8");
    doRead(1'b0, 91, "R8");
  endtask

  task automatic tBadWrite();
    drive(1'b1, 1'b1, 151, 16'h1234);
    #1 chk(!memEn, "R9", memEn, 1'b0);
    @(negedge clk);
    release_req();
    chk(rspError && rspReady, "R9", {rspError, rspReady}, 2'b11);
    @(negedge clk);
    chk(!rspError && !rspReady, "R9", {rspError, rspReady}, 2'b00);
    doRead(1'b1, 151, "R9");
    doRead(1'b1, 150, "R9");
  endtask

  initial begin
    for (int b = 0; b < BYTES; b++) refB[b] = 8'((b * 37 + 11) ^ (b >> 3));
    for (int r = 0; r < ROWS; r++) ram[r] = {refB[2 * r], refB[2 * r + 1]};
    memRdata = '0;
    repeat (3) @(negedge clk);
    tReset();
    tByteReads();
    tWordReads();
    tBackToBack();
    tSplitReads();
    tWrap();
    tHeldOff();
    tByteWrites();
    tWordWrites();
    tBadWrite();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule